// File: doc/BRIEF.md
# DVMA Translation Control Registers

This block is the software-visible control face of an I/O address translation unit. It answers word-oriented bus reads and writes that fall inside an address span starting at a configurable base. Two words are implemented. Word 0 is a control register and word 1 holds the physical base of the translation page table. Every other word in the span reads as zero and ignores writes. Byte and halfword accesses behave as full-word accesses: the two low address bits are not used.

A write to the control word does two things. It stores the whole 32-bit value, and it decodes a 3-bit range code carried in that value into the lowest address of the translated DVMA window. The window always ends at the top of the 32-bit space. It is 16 MB long for code 0, and each higher code doubles it, up to 2 GB for code 7. The translation unit next to this block takes three registered outputs: the window start, the table base and the enable bit.

The bus accepts a request whenever `req_valid` is high (`req_ready` is always high). Read data comes back registered, one cycle after the request.

Top module: `dvma_ctl_regs`

## Requirements
- R1: After reset, the control word, the table base word, the window start and the enable output are all zero, and `rsp_valid` is low.
- R2: The word index is (address − BASE) >> 2, and the two low address bits are ignored. Index 0 selects the control word and index 1 selects the table base word.
- R3: A write to the control word stores all 32 bits. Bits [31:28] (implementation ID) and [27:24] (version) have no other effect. A read of the control word returns the stored value unchanged.
- R4: The range code is bits [4:2] of the written control value. The window start becomes 0xFFFFFFFF shifted left by (24 + code): code 0 gives 0xFF000000 and code 7 gives 0x80000000.
- R5: The window start changes only on a write to the control word. Writes to other words, and all reads, leave it unchanged.
- R6: `xlate_en` equals bit 0 of the last value written to the control word.
- R7: A write to word 1 stores the full value. It appears on `tbl_base` and is returned by reads of word 1.
- R8: Inside the span, a write to a word other than 0 or 1 changes no state, and a read of such a word returns zero.
- R9: A read inside the span raises `rsp_valid` for exactly one cycle, one clock after the request, with the data on `rsp_rdata`. Writes produce no response.
- R10: A request outside [BASE, BASE + 4·SPAN_WORDS) gets no response and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Always high; every request is accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| win_start | output | 32 | Lowest address of the translated window |
| tbl_base | output | 32 | Page-table base register |
| xlate_en | output | 1 | Translation enable |

## Verification
All eight range codes are written to the control word, each with a different ID, version and enable pattern. This separates errors in the code decode from errors in storing the whole word. Every word index in a small stretch of the span is written and read back, and some accesses use non-zero low address bits. This tells apart the two implemented words, the ignored words, and any wrong use of the byte offset. Writes to the table base and to unimplemented words are placed between control writes, which shows that the window start is recomputed only on control writes. Addresses just below the base and just past the end of the span show where the span boundaries fall.

// File: rtl/dvma_regs_pkg.sv
`timescale 1ns/1ps
package dvma_regs_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned RANGE_LSB = 2;
    localparam int unsigned RANGE_W   = 3;
    localparam int unsigned EN_BIT    = 0;

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] tbl;
        logic [WORD_W-1:0] win;
        logic              rsp_vld;
        logic [WORD_W-1:0] rsp_data;
    } regs_t;
endpackage

// File: rtl/dvma_addr_decode.sv
`timescale 1ns/1ps
module dvma_addr_decode #(
    parameter int unsigned          ADDR_W     = 32,
    parameter logic [ADDR_W-1:0]    BASE       = 32'h0800_0000,
    parameter int unsigned          SPAN_WORDS = 3 * 4096
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_span,
    output logic              sel_ctrl,
    output logic              sel_tbl
);
    localparam logic [ADDR_W:0] SPAN_BYTES = (ADDR_W+1)'(SPAN_WORDS) << 2;

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-3:0] word_idx;

    always_comb begin
        offset   = addr - BASE;
        word_idx = offset[ADDR_W-1:2];
        in_span  = (addr >= BASE) && ({1'b0, offset} < SPAN_BYTES);
        sel_ctrl = in_span && (word_idx == '0);
        sel_tbl  = in_span && (word_idx == (ADDR_W-2)'(1));
    end

    // R2: at most one word selected, and a selection implies in_span
    always_comb begin
        if (!$isunknown(addr)) begin
            assert_one_select_R2: assert ($onehot0({sel_ctrl, sel_tbl}) && (in_span || !(sel_ctrl || sel_tbl)))
                else $error("decoder selected more than one word");
        end
    end
endmodule

// File: rtl/dvma_window_calc.sv
`timescale 1ns/1ps
module dvma_window_calc #(
    parameter int unsigned RANGE_W  = 3,
    parameter int unsigned MIN_LOG2 = 24,
    parameter int unsigned WORD_W   = 32
) (
    input  logic [RANGE_W-1:0] code,
    output logic [WORD_W-1:0]  start
);
    localparam int unsigned NCODES = 1 << RANGE_W;

    logic [WORD_W-1:0] table_q [NCODES];

    for (genvar k = 0; k < NCODES; k++) begin : g_code
        assign table_q[k] = {WORD_W{1'b1}} << (MIN_LOG2 + k);
    end

    assign start = table_q[code];

    // R4: the window start carries (WORD_W - MIN_LOG2 - code) leading ones
    always_comb begin
        if (!$isunknown(code)) begin
            assert_window_ones_R4: assert ($countones(start) == (WORD_W - MIN_LOG2 - int'(code)))
                else $error("window start has wrong number of ones");
        end
    end
endmodule

// File: rtl/dvma_ctl_regs.sv
`timescale 1ns/1ps
module dvma_ctl_regs
    import dvma_regs_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] BASE       = 32'h0800_0000,
    parameter int unsigned       SPAN_WORDS = 3 * 4096,
    parameter int unsigned       MIN_LOG2   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic [WORD_W-1:0] win_start,
    output logic [WORD_W-1:0] tbl_base,
    output logic              xlate_en
);
    logic              in_span, sel_ctrl, sel_tbl;
    logic [WORD_W-1:0] win_calc;
    regs_t             regs_d, regs_q;

    dvma_addr_decode #(
        .ADDR_W(ADDR_W), .BASE(BASE), .SPAN_WORDS(SPAN_WORDS)
    ) u_decode (
        .addr(req_addr), .in_span(in_span), .sel_ctrl(sel_ctrl), .sel_tbl(sel_tbl)
    );

    dvma_window_calc #(
        .RANGE_W(RANGE_W), .MIN_LOG2(MIN_LOG2), .WORD_W(WORD_W)
    ) u_window (
        .code(req_wdata[RANGE_LSB +: RANGE_W]), .start(win_calc)
    );

    always_comb begin
        regs_d         = regs_q;
        regs_d.rsp_vld = 1'b0;
        if (req_valid && in_span) begin
            if (req_write) begin
                if (sel_ctrl) begin
                    regs_d.ctrl = req_wdata;
                    regs_d.win  = win_calc;
                end
                if (sel_tbl) begin
                    regs_d.tbl = req_wdata;
                end
            end else begin
                regs_d.rsp_vld  = 1'b1;
                regs_d.rsp_data = sel_ctrl ? regs_q.ctrl :
                                  sel_tbl  ? regs_q.tbl  : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign req_ready = 1'b1;
    assign rsp_valid = regs_q.rsp_vld;
    assign rsp_rdata = regs_q.rsp_data;
    assign win_start = regs_q.win;
    assign tbl_base  = regs_q.tbl;
    assign xlate_en  = regs_q.ctrl[EN_BIT];

    logic ctrl_wr, rd_acc, other_wr;
    assign ctrl_wr  = req_valid && req_write && sel_ctrl;
    assign rd_acc   = req_valid && !req_write && in_span;
    assign other_wr = req_valid && req_write && !sel_ctrl && !sel_tbl;

    // R5: window start holds unless the control word is written
    assert_win_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(win_start))
        else $error("window start moved without a control write");

    // R6: enable follows bit 0 of the written control value
    assert_enable_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (xlate_en == $past(req_wdata[EN_BIT])))
        else $error("enable does not follow written bit 0");

    // R9: a read inside the span answers exactly one cycle later
    assert_rsp_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> rsp_valid)
        else $error("read response missing");
    assert_rsp_only_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> !rsp_valid)
        else $error("response without a read");

    // R8 / R10: writes to unimplemented or out-of-span words change nothing
    assert_ignored_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        other_wr |=> ($stable(tbl_base) && $stable(win_start) && $stable(xlate_en)))
        else $error("ignored write changed state");
endmodule

// File: tb/dvma_ctl_regs_bench.sv
`timescale 1ns/1ps
module dvma_ctl_regs_bench;
    localparam logic [31:0] BASE = 32'h0800_0000;
    localparam int unsigned SPAN = 3 * 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, xlate_en;
    logic [31:0] rsp_rdata, win_start, tbl_base;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_ctrl = '0, exp_tbl = '0, exp_win = '0;

    always #2.5 clk = ~clk;

    dvma_ctl_regs #(.ADDR_W(32), .BASE(BASE), .SPAN_WORDS(SPAN)) u_dvma_ctl_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .win_start(win_start),
        .tbl_base(tbl_base), .xlate_en(xlate_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check({req, " win_start"}, win_start, exp_win);
        check({req, " tbl_base"}, tbl_base, exp_tbl);
        check({req, " xlate_en"}, {31'd0, xlate_en}, {31'd0, exp_ctrl[0]});
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        // R9: writes give no response
        check("R9 no write response", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic bus_read(input logic [31:0] a, output logic vld, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        vld = rsp_valid; d = rsp_rdata;
        @(negedge clk);
        // R9: response lasts a single cycle
        check("R9 single-cycle response", {31'd0, rsp_valid}, 32'd0);
    endtask

    function automatic logic [31:0] model_win(input int code);
        logic [31:0] v = 32'h8000_0000;
        for (int i = 0; i < 7 - code; i++) v = {1'b1, v[31:1]};
        return v;
    endfunction

    initial begin
        #(200000 * 5);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic        v;
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_outputs("R1 reset");
        check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R1 req_ready", {31'd0, req_ready}, 32'd1);
        rst_n = 1'b1;
        bus_read(BASE, v, d);
        check("R1 ctrl after reset", d, 32'd0);

        // R3 R4 R6: sweep all range codes with varied ID/version/enable
        for (int c = 0; c < 8; c++) begin
            logic [31:0] w;
            w = {4'(c + 3), 4'(9 - c), 19'h1A5A5 ^ 19'(c * 7919), 3'(c), 1'b0, 1'(c & 1)};
            bus_write(BASE, w);
            exp_ctrl = w; exp_win = model_win(c);
            check_outputs($sformatf("R4 code %0d", c));
            bus_read(BASE, v, d);
            check("R9 ctrl read valid", {31'd0, v}, 32'd1);
            check("R3 ctrl readback", d, exp_ctrl);
        end

        // R7: table base, R5: window held across it
        bus_write(BASE + 32'd4, 32'hDEAD_B00C);
        exp_tbl = 32'hDEAD_B00C;
        check_outputs("R7 R5 tbl write");
        bus_read(BASE + 32'd4, v, d);
        check("R7 tbl readback", d, exp_tbl);

        // R2: low address bits ignored
        bus_write(BASE + 32'd6, 32'h1234_5678);
        exp_tbl = 32'h1234_5678;
        check_outputs("R2 unaligned tbl write");
        bus_write(BASE + 32'd3, 32'hA000_0011);
        exp_ctrl = 32'hA000_0011; exp_win = model_win(4);
        check_outputs("R2 unaligned ctrl write");
        bus_read(BASE + 32'd1, v, d);
        check("R2 unaligned ctrl read", d, exp_ctrl);

        // R8: unimplemented words within span; R5 window unchanged
        for (int k = 2; k < 12; k++) begin
            bus_write(BASE + 32'(k * 4), 32'hFFFF_FFFE);
            check_outputs($sformatf("R8 R5 word %0d write", k));
            bus_read(BASE + 32'(k * 4), v, d);
            check("R8 read valid", {31'd0, v}, 32'd1);
            check("R8 read zero", d, 32'd0);
        end
        bus_write(BASE + 32'((SPAN - 1) * 4), 32'hFFFF_FFFF);
        check_outputs("R8 last word write");
        bus_read(BASE + 32'((SPAN - 1) * 4), v, d);
        check("R8 last word valid", {31'd0, v}, 32'd1);
        check("R8 last word zero", d, 32'd0);

        // R10: outside the span
        bus_write(BASE - 32'd4, 32'h0000_001C);
        check_outputs("R10 below base write");
        bus_write(BASE + 32'(SPAN * 4), 32'h0000_0000);
        check_outputs("R10 past span write");
        bus_read(BASE - 32'd4, v, d);
        check("R10 below base no response", {31'd0, v}, 32'd0);
        bus_read(BASE + 32'(SPAN * 4), v, d);
        check("R10 past span no response", {31'd0, v}, 32'd0);

        // R6: disable again
        bus_write(BASE, 32'h0000_0008);
        exp_ctrl = 32'h0000_0008; exp_win = model_win(2);
        check_outputs("R6 disable");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule